// File: doc/BRIEF.md
# Control Tick and Gate Generator

This block sets the integration period of a photon-counting tip-tilt loop. A prescaler divides the system clock down to a base period of 0.5 ms at a 40 MHz clock. A period counter advances once per base period. When it reaches a programmed compare value it restarts and issues a one-cycle control tick. The tick period is therefore the compare value times the base period, from 1 ms to 62 ms in 0.5 ms steps.

The same prescaler also drives a gate signal that enables and disables the photon counters. The gate repeats every base period, and its on-time is set by a 5-bit duty code in 32 linear steps. Because both outputs come from one phase counter, every tick falls on the first cycle of a gate period.

The host loads the compare value, the duty code and the sync mode through a small write port. In external mode the internal tick is suppressed. A synchronized rising edge on the sync input then produces the tick and restarts the base period.

Top module: `tickgen_top`

## Requirements
- R1: After reset `tick` and `gate` are low, the duty code in force is 0 and the compare value in force is 2, so the first ticks arrive every 2 base periods.
- R2: The base period lasts STEP_CLKS·32 clock cycles. Outside an external restart, the phase counter steps by one each cycle and wraps to 0 after its last value.
- R3: In internal mode with compare value N in force, `tick` is high for exactly one cycle and consecutive ticks are N base periods apart.
- R4: A write to address 0 sets the compare value from `wrData` (8 bits, unsigned). Values below 2 are stored as 2 and values above 124 are stored as 124.
- R5: A new compare value takes effect only at the next tick. The interval already in progress finishes with the old value.
- R6: A write to address 1 sets the duty code k from `wrData[4:0]`. The gate is high during the first k·STEP_CLKS cycles of each base period. Code 0 keeps the gate low and code 31 keeps it high throughout.
- R7: A new duty code takes effect at the start of the next base period, so no gate period is shortened or lengthened.
- R8: Every tick falls on the first cycle of a base period, so with a nonzero duty code the gate is high in the tick cycle.
- R9: A write to address 2 selects external sync when `wrData[0]` is 1. In that mode no internal tick is produced. A rising edge on `extSync` yields a tick in the third cycle after the edge is sampled, and the base period restarts in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Host write strobe |
| wrAddr | input | 2 | Host register select: 0 compare, 1 duty, 2 mode |
| wrData | input | 8 | Host write data |
| extSync | input | 1 | Asynchronous external sync input |
| tick | output | 1 | One-cycle control tick strobe |
| gate | output | 1 | Counter gate level, active high |

## Verification
A phase counter that slips is visible within one base period. The gate edge moves away from the tick, and the gate high count per period changes. A wrong period count or a compare value taken at the wrong moment shows up as a tick interval that is off by a whole base period, either at the first tick after a write or at the second. A broken synchronizer or edge detector moves an external tick off its third-cycle slot, or lets internal ticks appear in external mode, as soon as one edge is applied.

// File: rtl/tickgen_pkg.sv
package tickgen_pkg;
  // Strobes handed from the control section to the datapath
  typedef struct packed {
    logic baseWrap;   // last cycle of a base period
    logic extRestart; // synchronized external edge while external mode is on
    logic extMode;    // external sync selected
  } tickCtl_t;

  localparam logic [1:0] ADDR_CMP  = 2'd0;
  localparam logic [1:0] ADDR_DUTY = 2'd1;
  localparam logic [1:0] ADDR_MODE = 2'd2;
endpackage

// File: rtl/tickgen_ctrl.sv
module tickgen_ctrl
  import tickgen_pkg::*;
#(
  parameter int STEP_CLKS = 625,
  parameter int DUTY_W    = 5,
  parameter int CMP_W     = 7,
  parameter int CMP_MIN   = 2,
  parameter int CMP_MAX   = 124,
  parameter int CMP_RST   = 2,
  parameter int DATA_W    = 8,
  localparam int PRESCALE = STEP_CLKS << DUTY_W,
  localparam int PH_W     = $clog2(PRESCALE)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              extSync,
  output tickCtl_t          ctl,
  output logic [PH_W-1:0]   phase,
  output logic [CMP_W-1:0]  cmpReg,
  output logic [DUTY_W-1:0] dutyReg
);
  logic extModeQ;
  logic sync1, sync2, sync3;
  logic extEdge;
  logic wrap;

  // Host registers, compare value clamped on entry
  always_ff @(posedge clk) begin
    if (rst) begin
      cmpReg   <= CMP_W'(CMP_RST);
      dutyReg  <= '0;
      extModeQ <= 1'b0;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_CMP: begin
          if (int'(wrData) < CMP_MIN)      cmpReg <= CMP_W'(CMP_MIN);
          else if (int'(wrData) > CMP_MAX) cmpReg <= CMP_W'(CMP_MAX);
          else                             cmpReg <= wrData[CMP_W-1:0];
        end
        ADDR_DUTY: dutyReg  <= wrData[DUTY_W-1:0];
        ADDR_MODE: extModeQ <= wrData[0];
        default: ;
      endcase
    end
  end

  // Two-stage synchronizer plus an edge stage
  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
      sync3 <= 1'b0;
    end else begin
      sync1 <= extSync;
      sync2 <= sync1;
      sync3 <= sync2;
    end
  end

  assign extEdge = sync2 & ~sync3;
  assign wrap    = (phase == PH_W'(PRESCALE - 1));

  // Base-period prescaler, restarted by an accepted external edge
  always_ff @(posedge clk) begin
    if (rst)                        phase <= '0;
    else if (extModeQ && extEdge)   phase <= '0;
    else if (wrap)                  phase <= '0;
    else                            phase <= phase + PH_W'(1);
  end

  always_comb begin
    ctl.baseWrap   = wrap;
    ctl.extRestart = extModeQ & extEdge;
    ctl.extMode    = extModeQ;
  end
endmodule

// File: rtl/tickgen_dp.sv
module tickgen_dp
  import tickgen_pkg::*;
#(
  parameter int STEP_CLKS = 625,
  parameter int DUTY_W    = 5,
  parameter int CMP_W     = 7,
  parameter int CMP_RST   = 2,
  localparam int PRESCALE = STEP_CLKS << DUTY_W,
  localparam int PH_W     = $clog2(PRESCALE),
  localparam logic [DUTY_W-1:0] DUTY_TOP = {DUTY_W{1'b1}}
) (
  input  logic              clk,
  input  logic              rst,
  input  tickCtl_t          ctl,
  input  logic [PH_W-1:0]   phase,
  input  logic [CMP_W-1:0]  cmpReg,
  input  logic [DUTY_W-1:0] dutyReg,
  output logic              tickOut,
  output logic              gateOut
);
  logic [CMP_W-1:0]  cnt;
  logic [CMP_W-1:0]  cmpActive;
  logic [DUTY_W-1:0] dutyActive;
  logic [PH_W:0]     onLen;
  logic              periodEnd;

  assign periodEnd = (cnt == cmpActive - CMP_W'(1));

  // Period counter; compare shadow reloads only when a tick is issued
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      cmpActive <= CMP_W'(CMP_RST);
      tickOut   <= 1'b0;
    end else if (ctl.extRestart) begin
      cnt       <= '0;
      cmpActive <= cmpReg;
      tickOut   <= 1'b1;
    end else if (ctl.baseWrap && !ctl.extMode) begin
      if (periodEnd) begin
        cnt       <= '0;
        cmpActive <= cmpReg;
        tickOut   <= 1'b1;
      end else begin
        cnt     <= cnt + CMP_W'(1);
        tickOut <= 1'b0;
      end
    end else begin
      tickOut <= 1'b0;
    end
  end

  // Duty code reloads at the start of each base period
  always_ff @(posedge clk) begin
    if (rst)                                   dutyActive <= '0;
    else if (ctl.extRestart || ctl.baseWrap)   dutyActive <= dutyReg;
  end

  assign onLen   = (PH_W+1)'(dutyActive) * (PH_W+1)'(STEP_CLKS);
  assign gateOut = (dutyActive == DUTY_TOP) || ({1'b0, phase} < onLen);
endmodule

// File: rtl/tickgen_top.sv
module tickgen_top
  import tickgen_pkg::*;
#(
  parameter int STEP_CLKS = 625,
  parameter int DUTY_W    = 5,
  parameter int CMP_W     = 7,
  parameter int CMP_MIN   = 2,
  parameter int CMP_MAX   = 124,
  parameter int CMP_RST   = 2,
  localparam int PRESCALE = STEP_CLKS << DUTY_W,
  localparam int PH_W     = $clog2(PRESCALE)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wrEn,
  input  logic [1:0] wrAddr,
  input  logic [7:0] wrData,
  input  logic       extSync,
  output logic       tick,
  output logic       gate
);
  tickCtl_t          ctlS;
  logic [PH_W-1:0]   phaseW;
  logic [CMP_W-1:0]  cmpRegW;
  logic [DUTY_W-1:0] dutyRegW;

  tickgen_ctrl #(
    .STEP_CLKS(STEP_CLKS), .DUTY_W(DUTY_W), .CMP_W(CMP_W),
    .CMP_MIN(CMP_MIN), .CMP_MAX(CMP_MAX), .CMP_RST(CMP_RST), .DATA_W(8)
  ) i_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .extSync(extSync), .ctl(ctlS), .phase(phaseW), .cmpReg(cmpRegW),
    .dutyReg(dutyRegW)
  );

  tickgen_dp #(
    .STEP_CLKS(STEP_CLKS), .DUTY_W(DUTY_W), .CMP_W(CMP_W), .CMP_RST(CMP_RST)
  ) i_dp (
    .clk(clk), .rst(rst), .ctl(ctlS), .phase(phaseW), .cmpReg(cmpRegW),
    .dutyReg(dutyRegW), .tickOut(tick), .gateOut(gate)
  );
endmodule

// File: rtl/tickgen_chk.sv
module tickgen_chk #(
  parameter int STEP_CLKS = 625,
  parameter int DUTY_W    = 5,
  parameter int CMP_W     = 7,
  parameter int CMP_MIN   = 2,
  parameter int CMP_MAX   = 124,
  localparam int PRESCALE = STEP_CLKS << DUTY_W,
  localparam int PH_W     = $clog2(PRESCALE)
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              gate,
  input logic [PH_W-1:0]   phase,
  input logic [CMP_W-1:0]  cmpReg,
  input logic [DUTY_W-1:0] dutyReg
);
  // R3
  tick_single_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  // R8
  tick_phase_chk: assert property (@(posedge clk) disable iff (rst)
    tick |-> (phase == '0));

  // R4
  cmp_range_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(cmpReg) >= CMP_MIN) && (int'(cmpReg) <= CMP_MAX));

  // R7
  gate_start_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == '0) |-> (gate == ($past(dutyReg) != '0)));

  // R2
  phase_step_chk: assert property (@(posedge clk) disable iff (rst)
    (phase != '0) |-> (phase == $past(phase) + PH_W'(1)));
endmodule

bind tickgen_top tickgen_chk #(
  .STEP_CLKS(STEP_CLKS), .DUTY_W(DUTY_W), .CMP_W(CMP_W),
  .CMP_MIN(CMP_MIN), .CMP_MAX(CMP_MAX)
) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .gate(gate), .phase(phaseW),
  .cmpReg(cmpRegW), .dutyReg(dutyRegW)
);

// File: tb/test_tickgen_top.sv
module test_tickgen_top;
  localparam int CLK_PERIOD = 10;
  localparam int STEP = 2;
  localparam int PRE  = STEP * 32;
  localparam int WATCHDOG = 190000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       extSync = 1'b0;
  logic       tick, gate;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  string curTag = "R1";

  tickgen_top #(.STEP_CLKS(STEP)) i_tickgen_top (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .extSync(extSync), .tick(tick), .gate(gate)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model
  int  pcM, cntM, cmpActM, cmpRegM, dutyActM, dutyRegM;
  bit  modeM, tickM;
  bit  syncQ[$];
  bit  lastSync;

  function automatic bit gateModel();
    return (dutyActM == 31) || (pcM < dutyActM * STEP);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      pcM = 0; cntM = 0; cmpActM = 2; cmpRegM = 2;
      dutyActM = 0; dutyRegM = 0; modeM = 0; tickM = 0;
      syncQ = '{0, 0}; lastSync = 0;
    end else begin
      bit edgeSeen;
      edgeSeen = syncQ[1] && !lastSync;
      lastSync = syncQ[1];
      syncQ.pop_back();
      syncQ.push_front(extSync);
      tickM = 0;
      if (modeM && edgeSeen) begin
        pcM = 0; cntM = 0; tickM = 1; cmpActM = cmpRegM; dutyActM = dutyRegM;
      end else begin
        if (pcM == PRE - 1) begin
          pcM = 0;
          dutyActM = dutyRegM;
          if (!modeM) begin
            if (cntM == cmpActM - 1) begin
              cntM = 0; tickM = 1; cmpActM = cmpRegM;
            end else cntM++;
          end
        end else pcM++;
      end
      if (wrEn) begin
        case (wrAddr)
          2'd0: cmpRegM = (wrData < 2) ? 2 : (wrData > 124) ? 124 : int'(wrData);
          2'd1: dutyRegM = int'(wrData[4:0]);
          2'd2: modeM = wrData[0];
          default: ;
        endcase
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      check(tick == tickM, {curTag, " tick"}, tick, tickM);
      check(gate == gateModel(), {curTag, " gate"}, gate, gateModel());
    end
    if (cycles > WATCHDOG) begin
      check(0, "watchdog", cycles, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitTick();
    do @(negedge clk); while (!tick);
  endtask

  task automatic tickInterval(output int n);
    waitTick();
    n = 0;
    do begin @(negedge clk); n++; end while (!tick);
  endtask

  task automatic gateCount(output int n);
    n = 0;
    for (int i = 0; i < PRE; i++) begin @(negedge clk); if (gate) n++; end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(tick == 0, "R1 tick at reset", tick, 0);
    check(gate == 0, "R1 gate at reset", gate, 0);
    rst = 1'b0;
    tickInterval(n);
    check(n == 2 * PRE, "R1 default period", n, 2 * PRE);

    // R3 / R5: new compare applies at next tick
    curTag = "R5";
    writeReg(2'd0, 8'd5);
    tickInterval(n);
    check(n == 5 * PRE, "R5 period after reload", n, 5 * PRE);
    curTag = "R3";
    tickInterval(n);
    check(n == 5 * PRE, "R3 period N=5", n, 5 * PRE);

    // R4: clamping
    curTag = "R4";
    writeReg(2'd0, 8'd0);
    waitTick();
    tickInterval(n);
    check(n == 2 * PRE, "R4 low clamp", n, 2 * PRE);
    writeReg(2'd0, 8'd200);
    waitTick();
    tickInterval(n);
    check(n == 124 * PRE, "R4 high clamp", n, 124 * PRE);
    writeReg(2'd0, 8'd3);
    waitTick();

    // R6 / R7 / R8 / R2: duty codes
    curTag = "R6";
    writeReg(2'd1, 8'd0);
    repeat (PRE) @(negedge clk);
    gateCount(n);
    check(n == 0, "R6 code 0", n, 0);
    curTag = "R7";
    writeReg(2'd1, 8'd1);
    repeat (PRE) @(negedge clk);
    gateCount(n);
    check(n == STEP, "R7 code 1", n, STEP);
    curTag = "R2";
    writeReg(2'd1, 8'd16);
    repeat (PRE) @(negedge clk);
    gateCount(n);
    check(n == 16 * STEP, "R2 code 16 half period", n, 16 * STEP);
    curTag = "R8";
    waitTick();
    check(gate == 1, "R8 gate high at tick", gate, 1);
    writeReg(2'd1, 8'd31);
    repeat (PRE) @(negedge clk);
    gateCount(n);
    check(n == PRE, "R6 code 31 always on", n, PRE);

    // R9: external sync
    curTag = "R9";
    writeReg(2'd1, 8'd10);
    writeReg(2'd2, 8'd1);
    n = 0;
    for (int i = 0; i < 4 * PRE; i++) begin @(negedge clk); if (tick) n++; end
    check(n == 0, "R9 no internal ticks", n, 0);
    repeat (5) @(negedge clk);
    extSync = 1'b1;
    @(negedge clk); check(tick == 0, "R9 tick not early 1", tick, 0);
    @(negedge clk); check(tick == 0, "R9 tick not early 2", tick, 0);
    @(negedge clk); check(tick == 1, "R9 tick on third cycle", tick, 1);
    @(negedge clk); check(tick == 0, "R9 tick one cycle", tick, 0);
    repeat (20) @(negedge clk);
    extSync = 1'b0;
    repeat (PRE / 2) @(negedge clk);
    extSync = 1'b1;
    repeat (PRE) @(negedge clk);
    writeReg(2'd2, 8'd0);
    curTag = "R3";
    tickInterval(n);
    check(n == 3 * PRE, "R3 internal resumes", n, 3 * PRE);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule